// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours in 24-hour form, a day-of-week count, date, month, a two-digit year and a separate century byte. A one-cycle pulse on `tick` advances the count by one second. Each carry runs on to the next field: the date wraps on the true month length, leap years are handled, and the year carries into the century.

Software reaches the fields through a byte-wide register port. It has one address bus shared by reads and writes, and read data comes back registered one cycle after the address. A transfer-enable bit in the control byte selects between two modes. While the bit is set, the visible registers follow the running counter. While it is clear, the visible registers are frozen, so a multi-byte read or write sees one consistent snapshot, and the hidden counter keeps counting. When the bit is set again, one of two things happens. If software wrote any field during the freeze, the written snapshot is loaded into the counter. Otherwise the visible copy simply picks up the time that has elapsed.

The upper three bits of the month byte carry outside state from the `aux_flags` input. Writes to the month byte never change them.

Top module: `bcd_calendar`

## Requirements
- R1: After a synchronous reset the time is 00:00:00, day-of-week 1, date 01, month 01, year 00 and century 20 (the CENT_RESET default). Transfer enable is set and `rd_data` is 0x00.
- R2: The field addresses are: 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year, 7 century. Address 0xF is the control byte, with transfer enable in bit 7; its other bits read 0 and are ignored on write. Every other address reads 0x00. `rd_data` shows the byte at `addr` one cycle after `addr` is presented.
- R3: Seconds and minutes count 00..59 in BCD and hours count 00..23. Each wraps to 00 and carries into the next field.
- R4: Day-of-week counts 1..7. It advances at each midnight carry and wraps from 7 to 1.
- R5: The date wraps to 01 after the last day of the month: 30 days for months 04, 06, 09 and 11, and 31 for the other non-February months. The month then advances, and 12 wraps to 01.
- R6: February has 29 days when the four-digit year (century*100+year) is divisible by 4, except for multiples of 100 that are not multiples of 400. Otherwise it has 28.
- R7: The year wraps from 99 to 00 and carries into the century, which wraps from 99 to 00.
- R8: A field write keeps only the field's valid bits: 7 for seconds and minutes, 6 for hours and date, 5 for month, 3 for day-of-week, and the full byte for year and century. The unused bits read as 0.
- R9: Bits 7:5 of the month byte always read the current `aux_flags`. A month write changes only bits 4:0.
- R10: While transfer enable is clear, the visible bytes do not change on ticks, but the hidden counter keeps counting. Setting the bit with no writes made during the freeze shows the advanced time.
- R11: Field writes made while transfer enable is clear change only the visible bytes. Setting the bit afterwards loads the whole visible snapshot into the counter, and counting continues from it.
- R12: A field write while transfer enable is set goes straight into the counter. A tick in the same cycle as that write is dropped, and so is a tick in the same cycle as a resume that loads a snapshot.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Write strobe for `addr` and `wr_data` |
| addr | input | ADDR_W | Register address for both reads and writes |
| wr_data | input | 8 | Write data |
| aux_flags | input | 3 | Outside state shown in month bits 7:5 |
| rd_data | output | 8 | Registered read data for the previous `addr` |

## Verification
The assertions on field ranges (seconds up to 59, hours up to 23, day-of-week never 0) assume that software writes only in-range BCD values after masking. The stimulus therefore writes only legal times, dates and weekdays, and the masking tests pick junk upper bits that leave a legal value once stripped. The assertions also take `tick` as a single-cycle pulse. The bench places the cases that combine ticks with writes or resumes on purpose, so the dropped-tick rules are exercised rather than left to chance.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  // BCD increment of one byte (valid BCD input)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                return v + 8'd1;
  endfunction

  // increment with wrap from top back to bottom
  function automatic logic [7:0] wrap_inc(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] bottom);
    if (v >= top) return bottom;
    else          return bcd_inc(v);
  endfunction

  function automatic logic [7:0] bcd_bin(input logic [7:0] v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cen);
    logic [7:0] b;
    b = (yr == 8'h00) ? bcd_bin(cen) : bcd_bin(yr);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [5:0] month_len(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                     return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                   return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import bcd_cal_pkg::*;
(
  input  cal_t cur,
  output cal_t nxt
);
  logic [7:0] s8, m8, h8, d8, mo8, y8, c8;
  logic [2:0] dw;
  logic [5:0] mlen;
  logic       cs, cm, ch, cd, cmo, cy;

  always_comb begin
    mlen = month_len(cur.mon, is_leap(cur.year, cur.cent));
    s8   = wrap_inc({1'b0, cur.sec},  8'h59, 8'h00);
    m8   = wrap_inc({1'b0, cur.min},  8'h59, 8'h00);
    h8   = wrap_inc({2'b0, cur.hour}, 8'h23, 8'h00);
    d8   = wrap_inc({2'b0, cur.date}, {2'b0, mlen}, 8'h01);
    mo8  = wrap_inc({3'b0, cur.mon},  8'h12, 8'h01);
    y8   = wrap_inc(cur.year, 8'h99, 8'h00);
    c8   = wrap_inc(cur.cent, 8'h99, 8'h00);
    dw   = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
    cs   = (cur.sec  >= 7'h59);
    cm   = cs  && (cur.min  >= 7'h59);
    ch   = cm  && (cur.hour >= 6'h23);
    cd   = ch  && (cur.date >= mlen);
    cmo  = cd  && (cur.mon  >= 5'h12);
    cy   = cmo && (cur.year >= 8'h99);

    nxt     = cur;
    nxt.sec = s8[6:0];
    if (cs)  nxt.min  = m8[6:0];
    if (cm)  nxt.hour = h8[5:0];
    if (ch) begin
      nxt.dow  = dw;
      nxt.date = d8[5:0];
    end
    if (cd)  nxt.mon  = mo8[4:0];
    if (cmo) nxt.year = y8;
    if (cy)  nxt.cent = c8;
  end
endmodule

// File: rtl/cal_field_write.sv
module cal_field_write
  import bcd_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  cal_t              base,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output cal_t              upd,
  output logic              hit
);
  localparam int NUM_FIELDS = 8;

  always_comb begin
    upd = base;
    hit = (addr < ADDR_W'(NUM_FIELDS));
    case (addr)
      ADDR_W'(0): upd.sec  = data[6:0];
      ADDR_W'(1): upd.min  = data[6:0];
      ADDR_W'(2): upd.hour = data[5:0];
      ADDR_W'(3): upd.dow  = data[2:0];
      ADDR_W'(4): upd.date = data[5:0];
      ADDR_W'(5): upd.mon  = data[4:0];
      ADDR_W'(6): upd.year = data;
      ADDR_W'(7): upd.cent = data;
      default:    upd = base;
    endcase
  end
endmodule

// File: rtl/cal_read_mux.sv
module cal_read_mux
  import bcd_cal_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 15,
  parameter int TE_BIT   = 7
) (
  input  cal_t              vis,
  input  logic [ADDR_W-1:0] addr,
  input  logic              te,
  input  logic [2:0]        aux,
  output logic [7:0]        q
);
  always_comb begin
    q = 8'h00;
    case (addr)
      ADDR_W'(0): q = {1'b0, vis.sec};
      ADDR_W'(1): q = {1'b0, vis.min};
      ADDR_W'(2): q = {2'b0, vis.hour};
      ADDR_W'(3): q = {5'b0, vis.dow};
      ADDR_W'(4): q = {2'b0, vis.date};
      ADDR_W'(5): q = {aux, vis.mon};
      ADDR_W'(6): q = vis.year;
      ADDR_W'(7): q = vis.cent;
      default: begin
        if (addr == ADDR_W'(CTL_ADDR)) q[TE_BIT] = te;
      end
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int         ADDR_W     = 4,
  parameter int         CTL_ADDR   = 15,
  parameter int         TE_BIT     = 7,
  parameter logic [7:0] CENT_RESET = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic [2:0]        aux_flags,
  output logic [7:0]        rd_data
);
  localparam cal_t RST_VAL = '{cent: CENT_RESET, year: 8'h00, mon: 5'h01,
                               date: 6'h01, dow: 3'd1, hour: 6'h00,
                               min: 7'h00, sec: 7'h00};

  cal_t       cnt, vis, adv, wbase, wupd, cnt_d, vis_d;
  logic       te, dirty, hit, wr_fld, wr_ctl, te_n, resume, dirty_d;
  logic [7:0] rd_n;

  cal_advance u_adv (.cur(cnt), .nxt(adv));

  assign wbase = te ? cnt : vis;

  cal_field_write #(.ADDR_W(ADDR_W)) u_wr (
    .base(wbase), .addr(addr), .data(wr_data), .upd(wupd), .hit(hit)
  );

  cal_read_mux #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .TE_BIT(TE_BIT)) u_rd (
    .vis(vis), .addr(addr), .te(te), .aux(aux_flags), .q(rd_n)
  );

  always_comb begin
    wr_fld = wr_en && hit;
    wr_ctl = wr_en && (addr == ADDR_W'(CTL_ADDR));
    te_n   = wr_ctl ? wr_data[TE_BIT] : te;
    resume = wr_ctl && wr_data[TE_BIT] && !te;

    if (resume && dirty)   cnt_d = vis;
    else if (te && wr_fld) cnt_d = wupd;
    else if (tick)         cnt_d = adv;
    else                   cnt_d = cnt;

    if (te_n)        vis_d = cnt_d;
    else if (wr_fld) vis_d = wupd;
    else             vis_d = vis;

    if (resume)               dirty_d = 1'b0;
    else if (!te && wr_fld)   dirty_d = 1'b1;
    else                      dirty_d = dirty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= RST_VAL;
      vis     <= RST_VAL;
      te      <= 1'b1;
      dirty   <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      cnt     <= cnt_d;
      vis     <= vis_d;
      te      <= te_n;
      dirty   <= dirty_d;
      rd_data <= rd_n;
    end
  end

  // R10
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!te && !wr_en) |=> $stable(vis));

  // R11
  running_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    te |-> (vis == cnt));

  // R11
  snapshot_load_chk: assert property (@(posedge clk) disable iff (rst)
    (resume && dirty) |=> (cnt == $past(vis)));

  // R3
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt.sec <= 7'h59) && (cnt.sec[3:0] <= 4'd9));

  // R3
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt.hour <= 6'h23);

  // R4
  dow_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt.dow != 3'd0);

  // R12
  tick_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (te && tick && !wr_en) |=> (cnt != $past(cnt)));
endmodule

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;
  logic       clk = 1'b0;
  logic       rst, tick, wr_en;
  logic [3:0] addr;
  logic [7:0] wr_data, rd_data;
  logic [2:0] aux_flags;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // behavioural model: index 0 sec,1 min,2 hour,3 dow,4 date,5 month,6 year,7 century
  int t[8];
  int v[8];
  bit te_m, dirty_m;
  int msk[8] = '{'h7F, 'h7F, 'h3F, 'h07, 'h3F, 'h1F, 'hFF, 'hFF};

  always #2 clk = ~clk;

  bcd_calendar dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .aux_flags(aux_flags), .rd_data(rd_data)
  );

  function automatic logic [7:0] tobcd(int x);
    return 8'(((x / 10) % 10) * 16 + (x % 10));
  endfunction

  function automatic int frombcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(int m, int y);
    bit lp;
    lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic minit();
    t = '{0, 0, 0, 1, 1, 1, 0, 20};
    v = t;
    te_m = 1;
    dirty_m = 0;
  endtask

  task automatic madvance();
    t[0]++;
    if (t[0] == 60) begin
      t[0] = 0; t[1]++;
      if (t[1] == 60) begin
        t[1] = 0; t[2]++;
        if (t[2] == 24) begin
          t[2] = 0;
          t[3] = (t[3] == 7) ? 1 : t[3] + 1;
          t[4]++;
          if (t[4] > mdays(t[5], t[7] * 100 + t[6])) begin
            t[4] = 1; t[5]++;
            if (t[5] == 13) begin
              t[5] = 1; t[6]++;
              if (t[6] == 100) begin
                t[6] = 0;
                t[7] = (t[7] + 1) % 100;
              end
            end
          end
        end
      end
    end
  endtask

  function automatic logic [7:0] mread(logic [3:0] a);
    logic [7:0] b;
    if (a < 4'd8) begin
      b = tobcd(v[int'(a)]);
      if (a == 4'd5) b = {aux_flags, b[4:0]};
      return b;
    end
    if (a == 4'hF) return {te_m, 7'b0};
    return 8'h00;
  endfunction

  task automatic mstep(bit tk, bit we, logic [3:0] a, logic [7:0] d);
    bit ten, res;
    int val;
    val = frombcd(d & 8'(msk[int'(a) % 8]));
    ten = (we && a == 4'hF) ? d[7] : te_m;
    res = we && (a == 4'hF) && d[7] && !te_m;
    if (res && dirty_m)               t = v;
    else if (te_m && we && a < 4'd8)  t[int'(a)] = val;
    else if (tk)                      madvance();
    if (!te_m && we && a < 4'd8) begin
      v[int'(a)] = val;
      dirty_m = 1;
    end
    if (res) dirty_m = 0;
    te_m = ten;
    if (te_m) v = t;
  endtask

  task automatic chk(logic [7:0] act, logic [7:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: rd_data actual %h expected %h at %0t", cur_req, act, exp_v, $time);
    end
  endtask

  // one clock: drive, advance model, compare registered read after the edge
  task automatic cyc(bit tk, bit we, logic [3:0] a, logic [7:0] d);
    logic [7:0] e;
    tick = tk; wr_en = we; addr = a; wr_data = d;
    e = mread(a);
    mstep(tk, we, a, d);
    @(posedge clk);
    #1;
    chk(rd_data, e);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d); cyc(0, 1, a, d); endtask
  task automatic rd(logic [3:0] a);                cyc(0, 0, a, 8'h00); endtask
  task automatic tk(logic [3:0] a);                cyc(1, 0, a, 8'h00); endtask

  task automatic rd_all();
    for (int i = 0; i < 8; i++) rd(4'(i));
    rd(4'hF);
    rd(4'h0);
  endtask

  task automatic set_all(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] dw,
                         logic [7:0] dt, logic [7:0] mo, logic [7:0] y, logic [7:0] c);
    wr(4'd7, c); wr(4'd6, y); wr(4'd5, mo); wr(4'd4, dt);
    wr(4'd3, dw); wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
  endtask

  // set 23:59:59 on a date, tick once, read everything back
  task automatic midnight(logic [7:0] dw, logic [7:0] dt, logic [7:0] mo,
                          logic [7:0] y, logic [7:0] c);
    set_all(8'h59, 8'h59, 8'h23, dw, dt, mo, y, c);
    tk(4'd4);
    rd_all();
  endtask

  initial begin
    rst = 1; tick = 0; wr_en = 0; addr = 0; wr_data = 0; aux_flags = 3'b000;
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1";
    chk(rd_data, 8'h00);
    rst = 0;
    minit();
    rd_all();

    cur_req = "R2";
    rd(4'h8); rd(4'hE); rd(4'hF);
    wr(4'hF, 8'hFF); rd(4'hF); rd(4'h9);

    cur_req = "R3";
    set_all(8'h58, 8'h59, 8'h23, 8'h02, 8'h10, 8'h06, 8'h25, 8'h20);
    tk(4'd0); tk(4'd1); tk(4'd2);
    rd_all();
    set_all(8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h06, 8'h25, 8'h20);
    tk(4'd2); rd_all();

    cur_req = "R4";
    midnight(8'h07, 8'h15, 8'h03, 8'h25, 8'h20);
    midnight(8'h03, 8'h15, 8'h03, 8'h25, 8'h20);

    cur_req = "R5";
    midnight(8'h01, 8'h30, 8'h04, 8'h25, 8'h20);
    midnight(8'h01, 8'h30, 8'h01, 8'h25, 8'h20);
    midnight(8'h01, 8'h31, 8'h01, 8'h25, 8'h20);
    midnight(8'h01, 8'h30, 8'h11, 8'h25, 8'h20);
    midnight(8'h01, 8'h28, 8'h02, 8'h25, 8'h20);
    midnight(8'h01, 8'h31, 8'h12, 8'h25, 8'h20);

    cur_req = "R6";
    midnight(8'h04, 8'h28, 8'h02, 8'h24, 8'h20);
    midnight(8'h04, 8'h29, 8'h02, 8'h24, 8'h20);
    midnight(8'h04, 8'h28, 8'h02, 8'h00, 8'h21);
    midnight(8'h04, 8'h28, 8'h02, 8'h00, 8'h20);
    midnight(8'h04, 8'h28, 8'h02, 8'h23, 8'h20);

    cur_req = "R7";
    midnight(8'h05, 8'h31, 8'h12, 8'h99, 8'h20);
    midnight(8'h05, 8'h31, 8'h12, 8'h99, 8'h99);

    cur_req = "R8";
    wr(4'd0, 8'hC5); wr(4'd2, 8'hE3); wr(4'd3, 8'hFB);
    wr(4'd4, 8'hD5); wr(4'd5, 8'hE9); wr(4'd1, 8'hA7);
    rd_all();

    cur_req = "R9";
    aux_flags = 3'b101; rd(4'd5);
    wr(4'd5, 8'hF2); rd(4'd5);
    aux_flags = 3'b010; rd(4'd5); rd(4'd5);
    aux_flags = 3'b000;

    cur_req = "R10";
    set_all(8'h10, 8'h20, 8'h08, 8'h02, 8'h10, 8'h06, 8'h25, 8'h20);
    wr(4'hF, 8'h00); rd(4'hF);
    for (int i = 0; i < 5; i++) tk(4'd0);
    rd_all();
    wr(4'hF, 8'h80); rd_all();

    cur_req = "R11";
    wr(4'hF, 8'h00);
    wr(4'd0, 8'h30); wr(4'd1, 8'h45); wr(4'd2, 8'h17);
    tk(4'd0); tk(4'd1); tk(4'd0);
    rd_all();
    wr(4'hF, 8'h80); rd_all();
    tk(4'd0); rd(4'd0);

    cur_req = "R12";
    cyc(1, 1, 4'd0, 8'h20); rd(4'd0); rd(4'd0);
    wr(4'hF, 8'h00); wr(4'd0, 8'h40);
    cyc(1, 1, 4'hF, 8'h80); rd(4'd0); rd(4'hF);
    wr(4'hF, 8'h00);
    cyc(1, 1, 4'hF, 8'h80); rd(4'd0); rd(4'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL %s: watchdog actual hung expected finished", cur_req);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule